// File: doc/BRIEF.md
# CAN Fault Confinement State Tracker

This block holds the two error counters of a CAN node, one for transmission and one for reception, and turns their values into the node's error state. An external protocol engine, which does the frame decoding, sends one-cycle strobes that classify each event: a transmit error, a receive error, a good transmission or a good reception. The tracker updates its counters from these strobes and reports a 2-bit state code. There is a warning level at 96 that sits below the error-passive level. A bus-off output tells the transmit path to stop driving the bus.

Once the transmit counter reaches 256, the node is bus off. It stays there until software clears the halt bit and the receive input then shows a set number of runs of consecutive recessive bits. These bits are sampled on a bit-time strobe. After the last run the node goes back to error active with both counters at zero. Every change of state code sets a sticky transition flag. The flag raises the interrupt output only while the interrupt enable input is high.

Top module: `faultConfineTop`

## Requirements
- R1: After reset the state code is 00, both counters are 0, and busOff, haltRd, transFlag and irq are all 0.
- R2: Outside bus off, each strobe moves its counter at the next clock edge. txErr adds 8 to the transmit counter and txOk subtracts 1 from it. rxErr adds 1 to the receive counter and rxOk subtracts 1 from it. When an add and a subtract arrive in the same cycle, their net effect is applied. Neither counter goes below 0.
- R3: The receive counter saturates at 255. The transmit counter is 9 bits wide and can hold 256.
- R4: One clock edge after the counters change, the state code follows them. It is 11 (bus off) when the transmit counter is 256 or more. Otherwise it is 10 (error passive) when either counter is 128 or more, 01 (warning) when either counter is 96 or more, and 00 (error active) when both counters are below 96.
- R5: When the node enters bus off, busOff goes to 1 and haltRd is forced to 1. From the cycle the transmit counter reaches 256 onward, the error and success strobes have no effect on either counter.
- R6: Leaving bus off requires haltRd to be 0 first. After that, RECOVERY_RUNS runs of RUN_BITS consecutive recessive (1) bits must be seen, each bit sampled when bitStrobe is high. A dominant (0) bit restarts the run in progress. Setting halt back to 1 discards all progress. One edge after the last run completes, the state code is 00 and both counters are 0.
- R7: Every change of the state code sets transFlag. The flag holds until flagClr is high at an edge. If a new change happens in the same cycle as flagClr, the flag stays set.
- R8: irq is 1 exactly when transFlag is 1 and intEn is 1.
- R9: Outside bus off, a write on haltWrEn loads haltWrData into the halt bit, and haltRd shows its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txErr | input | 1 | Transmit error event strobe |
| txOk | input | 1 | Successful transmission strobe |
| rxErr | input | 1 | Receive error event strobe |
| rxOk | input | 1 | Successful reception strobe |
| rxBit | input | 1 | Sampled receive bit, 1 is recessive |
| bitStrobe | input | 1 | Marks the cycle in which rxBit holds a new bit |
| haltWrEn | input | 1 | Write strobe for the halt bit |
| haltWrData | input | 1 | Value written to the halt bit |
| flagClr | input | 1 | Clears the transition flag |
| intEn | input | 1 | Transition interrupt enable |
| stateCode | output | 2 | Node state: 00 active, 01 warning, 10 passive, 11 bus off |
| busOff | output | 1 | High in bus off; blocks transmission |
| haltRd | output | 1 | Current halt bit |
| tecVal | output | 9 | Transmit error counter |
| recVal | output | 8 | Receive error counter |
| transFlag | output | 1 | Sticky state-transition flag |
| irq | output | 1 | Transition interrupt |

## Verification
The bench keeps the default thresholds and counter widths, so the sweeps step through every count of the receive counter from 0 up to saturation and back down, and through every step of the transmit counter up to 256, and check each threshold crossing in both directions. It builds the recovery logic with RUN_BITS set to 4 and RECOVERY_RUNS set to 6. With those values the bench can cover the exact completion boundary, a dominant bit in the middle of a run, and progress lost by setting halt again, all within a few hundred cycles.

// File: rtl/faultConfinePkg.sv
package faultConfinePkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_WARN    = 2'b01,
    ST_PASSIVE = 2'b10,
    ST_BUSOFF  = 2'b11
  } nodeState_e;

  typedef struct packed {
    logic freeze;
    logic clearAll;
    logic runEnable;
  } ctrlStrobes_t;

endpackage

// File: rtl/errCounter.sv
module errCounter #(
  parameter int W    = 8,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         hold,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] cnt
);
  localparam int SUM_W = W + $clog2(STEP + 1) + 1;
  localparam logic [SUM_W-1:0] MAX_V = SUM_W'((64'd1 << W) - 64'd1);
  localparam logic [SUM_W-1:0] STEP_V = SUM_W'(STEP);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(cnt);
    if (up) sum = sum + STEP_V;
    if (down && sum != '0) sum = sum - SUM_W'(1);
    if (sum > MAX_V) sum = MAX_V;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (clear) cnt <= '0;
    else if (!hold) cnt <= sum[W-1:0];
  end
endmodule

// File: rtl/runCounter.sv
module runCounter #(
  parameter int RUN_BITS      = 11,
  parameter int RECOVERY_RUNS = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic bitStrobe,
  input  logic rxBit,
  output logic done
);
  localparam int LEN_W = $clog2(RUN_BITS + 1);
  localparam int CNT_W = $clog2(RECOVERY_RUNS + 1);
  localparam logic [LEN_W-1:0] LAST_BIT = LEN_W'(RUN_BITS - 1);
  localparam logic [CNT_W-1:0] ALL_RUNS = CNT_W'(RECOVERY_RUNS);

  logic [LEN_W-1:0] runLen;
  logic [CNT_W-1:0] runCnt;

  assign done = (runCnt == ALL_RUNS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
      runCnt <= '0;
    end else if (!enable) begin
      runLen <= '0;
      runCnt <= '0;
    end else if (bitStrobe && !done) begin
      if (!rxBit) begin
        runLen <= '0;
      end else if (runLen == LAST_BIT) begin
        runLen <= '0;
        runCnt <= runCnt + CNT_W'(1);
      end else begin
        runLen <= runLen + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/errCountPath.sv
module errCountPath
  import faultConfinePkg::*;
#(
  parameter int TEC_W         = 9,
  parameter int REC_W         = 8,
  parameter int TX_STEP       = 8,
  parameter int RX_STEP       = 1,
  parameter int OFF_LIMIT     = 256,
  parameter int RUN_BITS      = 11,
  parameter int RECOVERY_RUNS = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErr,
  input  logic             txOk,
  input  logic             rxErr,
  input  logic             rxOk,
  input  logic             rxBit,
  input  logic             bitStrobe,
  input  ctrlStrobes_t     strobes,
  output logic [TEC_W-1:0] tecQ,
  output logic [REC_W-1:0] recQ,
  output logic             recovDone
);
  localparam logic [TEC_W-1:0] OFF_V = TEC_W'(OFF_LIMIT);

  logic hold;
  assign hold = strobes.freeze | (tecQ >= OFF_V);

  errCounter #(.W(TEC_W), .STEP(TX_STEP)) u_tec (
    .clk(clk), .rstN(rstN), .clear(strobes.clearAll), .hold(hold),
    .up(txErr), .down(txOk), .cnt(tecQ)
  );

  errCounter #(.W(REC_W), .STEP(RX_STEP)) u_rec (
    .clk(clk), .rstN(rstN), .clear(strobes.clearAll), .hold(hold),
    .up(rxErr), .down(rxOk), .cnt(recQ)
  );

  runCounter #(.RUN_BITS(RUN_BITS), .RECOVERY_RUNS(RECOVERY_RUNS)) u_run (
    .clk(clk), .rstN(rstN), .enable(strobes.runEnable && !strobes.clearAll),
    .bitStrobe(bitStrobe), .rxBit(rxBit), .done(recovDone)
  );
endmodule

// File: rtl/faultCtrl.sv
module faultCtrl
  import faultConfinePkg::*;
#(
  parameter int TEC_W      = 9,
  parameter int REC_W      = 8,
  parameter int WARN_LIMIT = 96,
  parameter int PASS_LIMIT = 128,
  parameter int OFF_LIMIT  = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TEC_W-1:0] tecVal,
  input  logic [REC_W-1:0] recVal,
  input  logic             recovDone,
  input  logic             haltWrEn,
  input  logic             haltWrData,
  input  logic             flagClr,
  input  logic             intEn,
  output nodeState_e       stateQ,
  output logic             haltQ,
  output logic             flagQ,
  output logic             irq,
  output ctrlStrobes_t     strobes
);
  localparam logic [TEC_W-1:0] T_WARN = TEC_W'(WARN_LIMIT);
  localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASS_LIMIT);
  localparam logic [TEC_W-1:0] T_OFF  = TEC_W'(OFF_LIMIT);
  localparam logic [REC_W-1:0] R_WARN = REC_W'(WARN_LIMIT);
  localparam logic [REC_W-1:0] R_PASS = REC_W'(PASS_LIMIT);

  nodeState_e level, stateNext;
  logic inBusOff, entering;

  always_comb begin
    if (tecVal >= T_OFF)                          level = ST_BUSOFF;
    else if (tecVal >= T_PASS || recVal >= R_PASS) level = ST_PASSIVE;
    else if (tecVal >= T_WARN || recVal >= R_WARN) level = ST_WARN;
    else                                           level = ST_ACTIVE;
  end

  assign inBusOff = (stateQ == ST_BUSOFF);

  always_comb begin
    if (inBusOff) stateNext = recovDone ? ST_ACTIVE : ST_BUSOFF;
    else          stateNext = level;
  end

  assign entering = !inBusOff && (stateNext == ST_BUSOFF);

  always_comb begin
    strobes.freeze    = inBusOff;
    strobes.runEnable = inBusOff && !haltQ;
    strobes.clearAll  = inBusOff && recovDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_ACTIVE;
      haltQ  <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (entering)      haltQ <= 1'b1;
      else if (haltWrEn) haltQ <= haltWrData;
      if (stateNext != stateQ) flagQ <= 1'b1;
      else if (flagClr)        flagQ <= 1'b0;
    end
  end

  assign irq = flagQ & intEn;
endmodule

// File: rtl/faultConfineTop.sv
module faultConfineTop
  import faultConfinePkg::*;
#(
  parameter int TEC_W         = 9,
  parameter int REC_W         = 8,
  parameter int TX_STEP       = 8,
  parameter int RX_STEP       = 1,
  parameter int WARN_LIMIT    = 96,
  parameter int PASS_LIMIT    = 128,
  parameter int OFF_LIMIT     = 256,
  parameter int RUN_BITS      = 11,
  parameter int RECOVERY_RUNS = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErr,
  input  logic             txOk,
  input  logic             rxErr,
  input  logic             rxOk,
  input  logic             rxBit,
  input  logic             bitStrobe,
  input  logic             haltWrEn,
  input  logic             haltWrData,
  input  logic             flagClr,
  input  logic             intEn,
  output logic [1:0]       stateCode,
  output logic             busOff,
  output logic             haltRd,
  output logic [TEC_W-1:0] tecVal,
  output logic [REC_W-1:0] recVal,
  output logic             transFlag,
  output logic             irq
);
  ctrlStrobes_t strobes;
  nodeState_e   stateQ;
  logic         recovDone;

  errCountPath #(
    .TEC_W(TEC_W), .REC_W(REC_W), .TX_STEP(TX_STEP), .RX_STEP(RX_STEP),
    .OFF_LIMIT(OFF_LIMIT), .RUN_BITS(RUN_BITS), .RECOVERY_RUNS(RECOVERY_RUNS)
  ) u_path (
    .clk(clk), .rstN(rstN), .txErr(txErr), .txOk(txOk), .rxErr(rxErr),
    .rxOk(rxOk), .rxBit(rxBit), .bitStrobe(bitStrobe), .strobes(strobes),
    .tecQ(tecVal), .recQ(recVal), .recovDone(recovDone)
  );

  faultCtrl #(
    .TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIMIT(WARN_LIMIT),
    .PASS_LIMIT(PASS_LIMIT), .OFF_LIMIT(OFF_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tecVal(tecVal), .recVal(recVal),
    .recovDone(recovDone), .haltWrEn(haltWrEn), .haltWrData(haltWrData),
    .flagClr(flagClr), .intEn(intEn), .stateQ(stateQ), .haltQ(haltRd),
    .flagQ(transFlag), .irq(irq), .strobes(strobes)
  );

  assign stateCode = stateQ;
  assign busOff    = (stateQ == ST_BUSOFF);
endmodule

// File: rtl/faultConfineChk.sv
module faultConfineChk #(
  parameter int TEC_W      = 9,
  parameter int REC_W      = 8,
  parameter int TX_STEP    = 8,
  parameter int WARN_LIMIT = 96,
  parameter int PASS_LIMIT = 128,
  parameter int OFF_LIMIT  = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       stateCode,
  input logic             busOff,
  input logic             haltRd,
  input logic [TEC_W-1:0] tecVal,
  input logic [REC_W-1:0] recVal,
  input logic             transFlag,
  input logic             rxErr,
  input logic             rxOk
);
  localparam logic [TEC_W-1:0] T_WARN = TEC_W'(WARN_LIMIT);
  localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASS_LIMIT);
  localparam logic [TEC_W-1:0] T_OFF  = TEC_W'(OFF_LIMIT);
  localparam logic [REC_W-1:0] R_WARN = REC_W'(WARN_LIMIT);
  localparam logic [REC_W-1:0] R_PASS = REC_W'(PASS_LIMIT);
  localparam logic [REC_W-1:0] R_MAX  = '1;
  localparam logic [TEC_W:0]   STEP_V = (TEC_W+1)'(TX_STEP);

  // R5: halt is forced on when bus off begins
  assert_busoff_halt_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOff) |-> haltRd);

  // R5 and R6: counters frozen while bus off, zero on exit
  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    busOff |=> (busOff ? ($stable(tecVal) && $stable(recVal))
                       : (tecVal == '0 && recVal == '0)));

  // R6: exit only after halt was cleared
  assert_exit_halt_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOff) |-> !$past(haltRd));

  // R4: warning code reflects counter levels of the previous cycle
  assert_warn_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 2'b01) |->
      (($past(tecVal) >= T_WARN || $past(recVal) >= R_WARN) &&
       $past(tecVal) < T_PASS && $past(recVal) < R_PASS));

  // R7: any state change leaves the flag set
  assert_flag_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != $past(stateCode)) |-> transFlag);

  // R2: transmit counter never rises by more than one step per cycle
  assert_tec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busOff |=> ({1'b0, tecVal} <= {1'b0, $past(tecVal)} + STEP_V));

  // R3: receive counter holds at its ceiling
  assert_rec_sat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (recVal == R_MAX && rxErr && !rxOk && !busOff && tecVal < T_OFF)
      |=> (recVal == R_MAX));
endmodule

bind faultConfineTop faultConfineChk #(
  .TEC_W(TEC_W), .REC_W(REC_W), .TX_STEP(TX_STEP), .WARN_LIMIT(WARN_LIMIT),
  .PASS_LIMIT(PASS_LIMIT), .OFF_LIMIT(OFF_LIMIT)
) u_chk (
  .clk(clk), .rstN(rstN), .stateCode(stateCode), .busOff(busOff),
  .haltRd(haltRd), .tecVal(tecVal), .recVal(recVal), .transFlag(transFlag),
  .rxErr(rxErr), .rxOk(rxOk)
);

// File: tb/faultConfineTop_tb.sv
module faultConfineTop_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_BITS_TB = 4;
  localparam int RUNS_TB = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txErr = 0, txOk = 0, rxErr = 0, rxOk = 0;
  logic rxBit = 1, bitStrobe = 0;
  logic haltWrEn = 0, haltWrData = 0, flagClr = 0, intEn = 0;
  logic [1:0] stateCode;
  logic busOff, haltRd, transFlag, irq;
  logic [8:0] tecVal;
  logic [7:0] recVal;

  int errs = 0;
  int checks = 0;
  int tecM = 0, recM = 0, stM = 0;
  bit offM = 0, flagM = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  faultConfineTop #(.RUN_BITS(RUN_BITS_TB), .RECOVERY_RUNS(RUNS_TB)) u_dut (
    .clk(clk), .rstN(rstN), .txErr(txErr), .txOk(txOk), .rxErr(rxErr),
    .rxOk(rxOk), .rxBit(rxBit), .bitStrobe(bitStrobe), .haltWrEn(haltWrEn),
    .haltWrData(haltWrData), .flagClr(flagClr), .intEn(intEn),
    .stateCode(stateCode), .busOff(busOff), .haltRd(haltRd), .tecVal(tecVal),
    .recVal(recVal), .transFlag(transFlag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int levelOf(input int t, input int r);
    if (t >= 256) return 3;
    if (t >= 128 || r >= 128) return 2;
    if (t >= 96 || r >= 96) return 1;
    return 0;
  endfunction

  task automatic checkAll(input string tag);
    chk({tag, " R2 tec"}, int'(tecVal), tecM);
    chk({tag, " R3 rec"}, int'(recVal), recM);
    chk({tag, " R4 state"}, int'(stateCode), stM);
    chk({tag, " R5 busOff"}, int'(busOff), int'(offM));
    chk({tag, " R7 flag"}, int'(transFlag), int'(flagM));
    chk({tag, " R8 irq"}, int'(irq), int'(flagM & intEn));
  endtask

  task automatic clearFlag();
    @(negedge clk); flagClr = 1;
    @(negedge clk); flagClr = 0;
    flagM = 0;
    chk("R7 cleared", int'(transFlag), 0);
  endtask

  // One event: inputs high for one edge, result checked two edges later
  task automatic evt(input bit te, input bit re, input bit to, input bit ro);
    int prev;
    prev = stM;
    @(negedge clk); txErr = te; rxErr = re; txOk = to; rxOk = ro;
    @(negedge clk); txErr = 0; rxErr = 0; txOk = 0; rxOk = 0;
    @(negedge clk);
    if (!offM && tecM < 256) begin
      tecM = tecM + (te ? 8 : 0);
      if (to && tecM > 0) tecM--;
      if (tecM > 511) tecM = 511;
      recM = recM + (re ? 1 : 0);
      if (ro && recM > 0) recM--;
      if (recM > 255) recM = 255;
    end
    if (!offM) begin
      stM = levelOf(tecM, recM);
      if (stM == 3) offM = 1;
    end
    if (stM != prev) flagM = 1;
    checkAll("evt");
    if (flagM) clearFlag();
  endtask

  task automatic sendBit(input bit b);
    @(negedge clk); rxBit = b; bitStrobe = 1;
    @(negedge clk); bitStrobe = 0; rxBit = 1;
  endtask

  task automatic writeHalt(input bit v);
    @(negedge clk); haltWrEn = 1; haltWrData = v;
    @(negedge clk); haltWrEn = 0;
  endtask

  task automatic driveToBusOff();
    while (!offM) evt(1, 0, 0, 0);
    chk("R5 halt forced", int'(haltRd), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", int'(stateCode), 0);
    chk("R1 tec", int'(tecVal), 0);
    chk("R1 rec", int'(recVal), 0);
    chk("R1 halt", int'(haltRd), 0);
    chk("R1 flag", int'(transFlag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 busOff", int'(busOff), 0);

    // R4 R7 R8: receive counter sweep through warning and passive and back
    intEn = 1;
    for (int i = 0; i < 140; i++) evt(0, 1, 0, 0);
    for (int i = 0; i < 145; i++) evt(0, 0, 0, 1);
    // R3: saturation of receive counter
    for (int i = 0; i < 262; i++) evt(0, 1, 0, 0);
    chk("R3 rec saturated", int'(recVal), 255);
    for (int i = 0; i < 260; i++) evt(0, 0, 0, 1);

    // R2: net effect of simultaneous events, floor at zero, irq masked
    intEn = 0;
    for (int i = 0; i < 5; i++) evt(1, 1, 1, 1);
    chk("R2 net tec", int'(tecVal), 35);
    for (int i = 0; i < 40; i++) evt(0, 0, 1, 0);
    chk("R2 tec floor", int'(tecVal), 0);
    for (int i = 0; i < 15; i++) evt(1, 0, 0, 0);
    for (int i = 0; i < 120; i++) evt(0, 0, 1, 0);
    intEn = 1;

    // R7: new transition coinciding with clear keeps flag set
    for (int i = 0; i < 95; i++) evt(0, 1, 0, 0);
    @(negedge clk); rxErr = 1;
    @(negedge clk); rxErr = 0; flagClr = 1;
    @(negedge clk); flagClr = 0;
    recM = 96; stM = 1;
    chk("R7 set wins over clear", int'(transFlag), 1);
    chk("R4 warn at 96", int'(stateCode), 1);
    clearFlag();
    for (int i = 0; i < 96; i++) evt(0, 0, 0, 1);

    // R9: halt writable outside bus off
    writeHalt(1);
    chk("R9 halt set", int'(haltRd), 1);
    writeHalt(0);
    chk("R9 halt clear", int'(haltRd), 0);

    // R5: bus off entry and frozen counters
    driveToBusOff();
    chk("R3 tec holds 256", int'(tecVal), 256);
    evt(0, 0, 1, 0);
    evt(0, 1, 0, 0);
    evt(1, 0, 0, 1);

    // R6: recessive bits ignored while halt is 1
    for (int i = 0; i < 40; i++) sendBit(1);
    @(negedge clk);
    chk("R6 no exit while halted", int'(busOff), 1);
    writeHalt(0);
    chk("R6 halt cleared", int'(haltRd), 0);
    // first run interrupted by a dominant bit
    for (int i = 0; i < RUN_BITS_TB - 1; i++) sendBit(1);
    sendBit(0);
    for (int r = 0; r < RUNS_TB - 1; r++)
      for (int i = 0; i < RUN_BITS_TB; i++) sendBit(1);
    for (int i = 0; i < RUN_BITS_TB - 1; i++) sendBit(1);
    @(negedge clk);
    chk("R6 one bit short", int'(busOff), 1);
    sendBit(1);
    @(negedge clk);
    chk("R6 recovered state", int'(stateCode), 0);
    chk("R6 tec cleared", int'(tecVal), 0);
    chk("R6 rec cleared", int'(recVal), 0);
    chk("R7 flag on recovery", int'(transFlag), 1);
    tecM = 0; recM = 0; stM = 0; offM = 0;
    clearFlag();

    // R6: setting halt again discards progress
    driveToBusOff();
    writeHalt(0);
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < RUN_BITS_TB; i++) sendBit(1);
    writeHalt(1);
    writeHalt(0);
    for (int r = 0; r < RUNS_TB - 1; r++)
      for (int i = 0; i < RUN_BITS_TB; i++) sendBit(1);
    for (int i = 0; i < RUN_BITS_TB - 1; i++) sendBit(1);
    @(negedge clk);
    chk("R6 progress discarded", int'(busOff), 1);
    sendBit(1);
    @(negedge clk);
    chk("R6 exit after full count", int'(stateCode), 0);
    chk("R8 irq on recovery", int'(irq), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule